// File: doc/BRIEF.md
# Stuck-Clock Loss Detector

This block watches a set of clocks that are asynchronous to one another and to the system. It uses one free-running reference clock to decide whether each of them is still alive. A monitored clock is declared lost when it shows no transition for a whole detection window. The input may be stuck at either level. The window is a parameter counted in reference cycles, and it should be chosen so that the resulting time lies between 10 µs and 125 µs. The default of 6400 cycles gives 64 µs with a 100 MHz reference.

Each monitored clock drives a toggle flop in its own domain. That flop is synchronized into the reference domain, and every change seen there restarts the clock's window counter. When the counter runs out, the loss flag is set. The flag clears on the first transition detected afterwards. Any change of a loss flag, in either direction, sets a sticky change flag. Software clears that flag by pulsing the matching write-one-to-clear input. A single interrupt output is raised while any change flag is set whose mask bit is 0.

Top module: `clk_loss_mon`

## Requirements
- R1: After reset every loss flag, every change flag and the interrupt output are 0.
- R2: A monitored clock that toggles at intervals well below the detection window never has its loss flag set.
- R3: A monitored clock held low for longer than TIMEOUT_CYCLES reference cycles, plus synchronizer latency, has its loss flag set to 1.
- R4: A monitored clock held high for longer than TIMEOUT_CYCLES reference cycles, plus synchronizer latency, has its loss flag set to 1.
- R5: A set loss flag returns to 0 within a few reference cycles of the monitored clock toggling again.
- R6: The change flag of a clock becomes 1 whenever that clock's loss flag changes value, and it stays 1 afterwards.
- R7: Pulsing bit i of `delta_clr` high for one cycle clears change flag i. A 0 in `delta_clr` leaves the flag unchanged. A clear never alters the loss flag. If a new change arrives in the same cycle as a clear, the set wins.
- R8: `irq` is 1 exactly when some clock has its change flag at 1 and its `irq_mask` bit at 0. A mask bit of 1 blocks that clock.
- R9: Each monitored clock has its own loss flag, change flag and counter, and a fault on one clock does not affect the others.
- R10: A loss flag is never set before its counter has seen TIMEOUT_CYCLES consecutive reference cycles without a detected transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | NUM_CLKS | Clocks being monitored |
| irq_mask | input | NUM_CLKS | Per-clock interrupt mask, 1 blocks |
| delta_clr | input | NUM_CLKS | Write-one-to-clear pulses for the change flags |
| loss | output | NUM_CLKS | Per-clock loss-of-clock flag |
| delta | output | NUM_CLKS | Sticky per-clock change flags |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check several rules on every cycle:
- a loss flag rises only after a full window without a transition;
- a detected transition drops the loss flag on the next cycle;
- the window counter stays inside its limit;
- a change flag follows every change of loss state and stays set unless it is cleared;
- a fully masked set of change flags keeps the interrupt low.

Other behaviour can only be shown by the bench's scenarios, with real clocks stopped at a chosen level and restarted. That covers detection at both stuck levels, recovery through the synchronizer, isolation between channels, and write-one-to-clear seen at the ports.

// File: rtl/clm_pkg.sv
package clm_pkg;
  // Number of flops between the toggle flop and the edge detector.
  localparam int unsigned CLM_SYNC_STAGES = 2;

  // Counter width needed to hold values 0..limit-1.
  function automatic int unsigned clm_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/clm_edge_sync.sv
module clm_edge_sync
  import clm_pkg::*;
(
  input  logic mon_clk_i,
  input  logic async_rst_n_i,
  input  logic ref_clk_i,
  input  logic ref_rst_n_i,
  output logic edge_o
);
  localparam int unsigned PIPE_W = CLM_SYNC_STAGES + 1;

  logic              tog_q;
  logic              tog_d;
  logic [PIPE_W-1:0] pipe_q;
  logic [PIPE_W-1:0] pipe_d;

  // The toggle flop in the monitored domain changes on every rising edge.
  always_comb tog_d = ~tog_q;

  always_ff @(posedge mon_clk_i or negedge async_rst_n_i) begin
    if (!async_rst_n_i) tog_q <= 1'b0;
    else                tog_q <= tog_d;
  end

  // The synchronizer chain and one extra stage for edge detection live in the reference domain.
  always_comb pipe_d = {pipe_q[PIPE_W-2:0], tog_q};

  always_ff @(posedge ref_clk_i or negedge ref_rst_n_i) begin
    if (!ref_rst_n_i) pipe_q <= '0;
    else              pipe_q <= pipe_d;
  end

  always_comb edge_o = pipe_q[PIPE_W-1] ^ pipe_q[PIPE_W-2];
endmodule

// File: rtl/clm_timeout.sv
module clm_timeout
  import clm_pkg::*;
#(
  parameter int unsigned LIMIT = 6400
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic edge_i,
  output logic loss_o,
  output logic chg_o
);
  localparam int unsigned CNT_W = clm_cnt_width(LIMIT);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             loss_q, loss_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    loss_d = loss_q;
    cnt_en = 1'b0;
    if (edge_i) begin
      cnt_d  = '0;
      loss_d = 1'b0;
      cnt_en = 1'b1;
    end else if (cnt_q == CNT_MAX) begin
      loss_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) loss_q <= 1'b0;
    else          loss_q <= loss_d;
  end

  always_comb begin
    loss_o = loss_q;
    chg_o  = loss_d ^ loss_q;
  end

  AST_LOSS_AFTER_FULL_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(loss_q) |-> $past(cnt_q) == CNT_MAX); // R10
  AST_EDGE_CLEARS_LOSS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    edge_i |=> !loss_q); // R5
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= CNT_MAX); // R3
endmodule

// File: rtl/clm_status.sv
module clm_status #(
  parameter int unsigned NUM_CLKS = 3
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic [NUM_CLKS-1:0] chg_i,
  input  logic [NUM_CLKS-1:0] clr_i,
  input  logic [NUM_CLKS-1:0] mask_i,
  output logic [NUM_CLKS-1:0] delta_o,
  output logic                irq_o
);
  logic [NUM_CLKS-1:0] delta_q, delta_d;

  // A new change takes priority over a clear in the same cycle.
  always_comb delta_d = (delta_q & ~clr_i) | chg_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) delta_q <= '0;
    else          delta_q <= delta_d;
  end

  always_comb begin
    delta_o = delta_q;
    irq_o   = |(delta_q & ~mask_i);
  end

  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_chk
    AST_DELTA_FOLLOWS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      chg_i[g] |=> delta_q[g]); // R6
    AST_DELTA_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      delta_q[g] && !clr_i[g] |=> delta_q[g]); // R7
  end
endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
  parameter int unsigned NUM_CLKS       = 3,
  parameter int unsigned TIMEOUT_CYCLES = 6400
) (
  input  logic                ref_clk,
  input  logic                rst_n,
  input  logic [NUM_CLKS-1:0] mon_clk,
  input  logic [NUM_CLKS-1:0] irq_mask,
  input  logic [NUM_CLKS-1:0] delta_clr,
  output logic [NUM_CLKS-1:0] loss,
  output logic [NUM_CLKS-1:0] delta,
  output logic                irq
);
  logic [1:0]          rst_sync_q;
  logic                ref_rst_n;
  logic [NUM_CLKS-1:0] edge_w;
  logic [NUM_CLKS-1:0] chg_w;

  // Reset is asserted asynchronously and released in step with the reference clock.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb ref_rst_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_CLKS; g++) begin : g_chan
    clm_edge_sync u_sync (
      .mon_clk_i     (mon_clk[g]),
      .async_rst_n_i (rst_n),
      .ref_clk_i     (ref_clk),
      .ref_rst_n_i   (ref_rst_n),
      .edge_o        (edge_w[g])
    );
    clm_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
      .clk_i   (ref_clk),
      .rst_n_i (ref_rst_n),
      .edge_i  (edge_w[g]),
      .loss_o  (loss[g]),
      .chg_o   (chg_w[g])
    );
  end

  clm_status #(.NUM_CLKS(NUM_CLKS)) u_stat (
    .clk_i   (ref_clk),
    .rst_n_i (ref_rst_n),
    .chg_i   (chg_w),
    .clr_i   (delta_clr),
    .mask_i  (irq_mask),
    .delta_o (delta),
    .irq_o   (irq)
  );

  AST_MASKED_NO_IRQ: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (delta & ~irq_mask) == '0 |-> !irq); // R8
endmodule

// File: tb/clk_loss_mon_bench.sv
module clk_loss_mon_bench;
  localparam int unsigned N   = 3;
  localparam int unsigned TMO = 100;

  logic         ref_clk = 1'b0;
  logic         rst_n   = 1'b0;
  logic [N-1:0] irq_mask  = '0;
  logic [N-1:0] delta_clr = '0;
  logic [N-1:0] run = '0;
  logic [N-1:0] lvl = '0;
  logic         mclk0 = 1'b0, mclk1 = 1'b0, mclk2 = 1'b0;
  logic [N-1:0] mon_clk;
  logic [N-1:0] loss, delta;
  logic         irq;
  int           n_chk = 0;
  int           n_fail = 0;

  always #5 ref_clk = ~ref_clk;
  always begin #23; mclk0 = run[0] ? ~mclk0 : lvl[0]; end
  always begin #37; mclk1 = run[1] ? ~mclk1 : lvl[1]; end
  always begin #51; mclk2 = run[2] ? ~mclk2 : lvl[2]; end
  assign mon_clk = {mclk2, mclk1, mclk0};

  clk_loss_mon #(.NUM_CLKS(N), .TIMEOUT_CYCLES(TMO)) u_clk_loss_mon (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk(mon_clk), .irq_mask(irq_mask),
    .delta_clr(delta_clr), .loss(loss), .delta(delta), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic pulse_clr(input logic [N-1:0] v);
    @(negedge ref_clk); delta_clr = v;
    @(negedge ref_clk); delta_clr = '0;
    wait_cyc(1);
  endtask

  task automatic t_reset;
    wait_cyc(1);
    chk("R1 loss", loss, 0);
    chk("R1 delta", delta, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_running;
    run = '1;
    wait_cyc(3 * TMO);
    chk("R2 loss all running", loss, 0);
    chk("R2 delta all running", delta, 0);
  endtask

  task automatic t_stuck_low;
    lvl[0] = 1'b0; run[0] = 1'b0;
    wait_cyc(TMO / 2);
    chk("R10 no early loss", loss[0], 0);
    wait_cyc(TMO + 20);
    chk("R3 loss stuck low", loss[0], 1);
    chk("R9 others unaffected", loss[2:1], 0);
    chk("R6 delta on rise", delta, 3'b001);
    chk("R8 irq unmasked", irq, 1);
  endtask

  task automatic t_mask;
    irq_mask = 3'b001; wait_cyc(1);
    chk("R8 irq masked", irq, 0);
    irq_mask = 3'b110; wait_cyc(1);
    chk("R8 irq other masks", irq, 1);
    irq_mask = '0;
  endtask

  task automatic t_clear;
    pulse_clr(3'b110);
    chk("R7 zero bit keeps delta", delta[0], 1);
    pulse_clr(3'b001);
    chk("R7 clear delta", delta[0], 0);
    chk("R7 clear keeps loss", loss[0], 1);
    chk("R8 irq after clear", irq, 0);
  endtask

  task automatic t_recover;
    run[0] = 1'b1;
    wait_cyc(20);
    chk("R5 loss cleared", loss[0], 0);
    chk("R6 delta on fall", delta[0], 1);
    wait_cyc(30);
    chk("R6 delta sticky", delta[0], 1);
    pulse_clr(3'b001);
    chk("R7 clear after recover", delta, 0);
  endtask

  task automatic t_stuck_high;
    lvl[1] = 1'b1; run[1] = 1'b0;
    wait_cyc(TMO + 30);
    chk("R4 loss stuck high", loss[1], 1);
    chk("R9 ch0 ch2 unaffected", {loss[2], loss[0]}, 0);
    chk("R6 delta ch1 only", delta, 3'b010);
    run[1] = 1'b1;
    wait_cyc(20);
    chk("R5 ch1 recovered", loss[1], 0);
  endtask

  initial begin
    repeat (3) @(posedge ref_clk);
    @(negedge ref_clk); rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_running();
    t_stuck_low();
    t_mask();
    t_clear();
    t_recover();
    t_stuck_high();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule